// File: doc/BRIEF.md
# Three-Phase Bridge PWM Mode Router

This block turns per-phase switch requests into gate commands for a six-switch, three-phase bridge. Each phase has a pair of enable inputs. The low-side enable asks for the phase's bottom switch and the high-side enable asks for its top switch. A single shared PWM input is steered by a two-bit chop mode. It can chop only the high-side switches, only the low-side switches, or both sides in a complementary fashion. Three fault bits from neighbouring blocks take priority over everything else: over-temperature, over-voltage and current limit.

Every output is registered on the system clock. Downstream dead-time insertion therefore sees glitch-free commands. Dead-time insertion and fault latching are done elsewhere. The number of phases is a parameter, with a default of three.

Top module: `bridge_pwm_router`

## Requirements
- R1: While reset is asserted, and on the first edge after it, every gate command is 0, whatever the inputs are.
- R2: A phase whose two enables are both 0 drives both of its gate commands to 0.
- R3: A phase whose two enables are both 1 is an illegal request and drives both of its gate commands to 0 in every mode.
- R4: With chop mode 2'b00 (chop high side), and no fault:
  - a phase with only the high enable set drives high = PWM and low = 0;
  - a phase with only the low enable set drives low = 1 and high = 0.
- R5: With chop mode 2'b10 (chop low side), and no fault:
  - a phase with only the low enable set drives low = PWM and high = 0;
  - a phase with only the high enable set drives high = 1 and low = 0.
- R6: Chop modes 2'b01 and 2'b11 are both complementary, and they behave identically:
  - a phase with only the high enable set drives high = PWM and low = not PWM;
  - a phase with only the low enable set drives low = 1 and high = 0.
- R7: No phase ever has its high and low gate commands at 1 in the same cycle.
- R8: If the over-temperature bit or the over-voltage bit is 1, every gate command is 0, whatever the mode, enables, PWM or current-limit bit.
- R9: While the current-limit bit is 1, the PWM input is treated as 0. As a result, no high-side switch conducts in chop modes 2'b00, 2'b01 and 2'b11.
- R10: Each phase's outputs depend only on its own enable pair and the shared inputs. Every output reflects the inputs sampled at the previous rising clock edge, so the latency is exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ph_lo_en | input | NUM_PHASES | Per-phase low-side request |
| ph_hi_en | input | NUM_PHASES | Per-phase high-side request |
| pwm_in | input | 1 | Shared PWM level |
| chop_mode | input | 2 | 00 chop high, 10 chop low, 01/11 complementary |
| flt_temp | input | 1 | Over-temperature fault bit |
| flt_volt | input | 1 | Over-voltage fault bit |
| flt_ilim | input | 1 | Current-limit fault bit |
| gate_hi | output | NUM_PHASES | Registered high-side gate commands |
| gate_lo | output | NUM_PHASES | Registered low-side gate commands |

## Verification
Each result is due exactly one rising edge after the inputs that produce it. The driver changes the inputs on a falling edge and queues the expected pair for each phase. The monitor compares that queued entry just after the next rising edge. A second check, taken just after each change of inputs and before the following rising edge, confirms that the outputs still hold the previous expectation. This guards the one-cycle latency of R10 against a path that bypasses the output register.

// File: rtl/bpr_pkg.sv
package bpr_pkg;

  typedef enum logic [1:0] {
    CHOP_HI = 2'b00,
    COMPL_A = 2'b01,
    CHOP_LO = 2'b10,
    COMPL_B = 2'b11
  } chop_mode_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } gate_pair_t;

  // Per-phase routing of an already fault-qualified PWM level.
  function automatic gate_pair_t route_phase(input chop_mode_e mode,
                                             input logic lo_req,
                                             input logic hi_req,
                                             input logic pwm);
    gate_pair_t g;
    g = '0;
    unique case ({lo_req, hi_req})
      2'b01: begin
        unique case (mode)
          CHOP_HI:          begin g.hi = pwm;  g.lo = 1'b0; end
          CHOP_LO:          begin g.hi = 1'b1; g.lo = 1'b0; end
          COMPL_A, COMPL_B: begin g.hi = pwm;  g.lo = ~pwm; end
          default:          g = '0;
        endcase
      end
      2'b10: begin
        g.hi = 1'b0;
        g.lo = (mode == CHOP_LO) ? pwm : 1'b1;
      end
      default: g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/bpr_fault_gate.sv
module bpr_fault_gate (
  input  logic pwm_in,
  input  logic flt_temp,
  input  logic flt_volt,
  input  logic flt_ilim,
  output logic pwm_eff,
  output logic kill_all
);
  always_comb begin
    kill_all = flt_temp | flt_volt;
    pwm_eff  = pwm_in & ~flt_ilim;
  end
endmodule

// File: rtl/bpr_phase_cell.sv
module bpr_phase_cell
  import bpr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo_req,
  input  logic       hi_req,
  input  logic       pwm_eff,
  input  logic       kill_all,
  input  chop_mode_e mode,
  output logic       hi_q,
  output logic       lo_q
);
  gate_pair_t nxt;

  always_comb begin
    nxt = route_phase(mode, lo_req, hi_req, pwm_eff);
    if (kill_all) nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= nxt.hi;
      lo_q <= nxt.lo;
    end
  end

  // R7: shoot-through never commanded
  a_r7_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_q && lo_q));

  // R2: idle phase off
  a_r2_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_req && !hi_req) |=> (!hi_q && !lo_q));

  // R3: illegal request off
  a_r3_both_req_off: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_req && hi_req) |=> (!hi_q && !lo_q));

  // R4: high-side chop follows PWM
  a_r4_hi_chop: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CHOP_HI && hi_req && !lo_req && !kill_all) |=> (hi_q == $past(pwm_eff) && !lo_q));
endmodule

// File: rtl/bridge_pwm_router.sv
module bridge_pwm_router
  import bpr_pkg::*;
#(
  parameter int NUM_PHASES = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PHASES-1:0] ph_lo_en,
  input  logic [NUM_PHASES-1:0] ph_hi_en,
  input  logic                  pwm_in,
  input  logic [1:0]            chop_mode,
  input  logic                  flt_temp,
  input  logic                  flt_volt,
  input  logic                  flt_ilim,
  output logic [NUM_PHASES-1:0] gate_hi,
  output logic [NUM_PHASES-1:0] gate_lo
);
  localparam int LAST_PH = NUM_PHASES - 1;

  logic       pwm_eff;
  logic       kill_all;
  chop_mode_e mode_q;

  assign mode_q = chop_mode_e'(chop_mode);

  bpr_fault_gate u_fault (
    .pwm_in  (pwm_in),
    .flt_temp(flt_temp),
    .flt_volt(flt_volt),
    .flt_ilim(flt_ilim),
    .pwm_eff (pwm_eff),
    .kill_all(kill_all)
  );

  for (genvar p = 0; p <= LAST_PH; p++) begin : g_phase
    bpr_phase_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .lo_req  (ph_lo_en[p]),
      .hi_req  (ph_hi_en[p]),
      .pwm_eff (pwm_eff),
      .kill_all(kill_all),
      .mode    (mode_q),
      .hi_q    (gate_hi[p]),
      .lo_q    (gate_lo[p])
    );
  end

  // R8: thermal or supply fault shuts every switch
  a_r8_fault_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_temp || flt_volt) |=> (gate_hi == '0 && gate_lo == '0));

  // R9: current limit leaves no high side conducting outside low-chop mode
  a_r9_ilim_no_high: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_ilim && chop_mode != 2'b10) |=> (gate_hi == '0));

  // R1: first edge after reset yields all-off
  a_r1_reset_off: assert property (@(posedge clk)
    !rst_n |=> (gate_hi == '0 && gate_lo == '0));
endmodule

// File: tb/sim_bridge_pwm_router.sv
module sim_bridge_pwm_router;
  localparam int NP = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] ph_lo_en = '0, ph_hi_en = '0;
  logic          pwm_in = 1'b0;
  logic [1:0]    chop_mode = 2'b00;
  logic          flt_temp = 1'b0, flt_volt = 1'b0, flt_ilim = 1'b0;
  logic [NP-1:0] gate_hi, gate_lo;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [NP-1:0] lo_en, hi_en;
    logic [1:0]    mode;
    logic          tf, ilim;
    logic [NP-1:0] e_hi, e_lo;
  } item_t;

  item_t         q[$];
  logic [NP-1:0] prev_hi = '0, prev_lo = '0;

  always #4 clk = ~clk;

  bridge_pwm_router #(.NUM_PHASES(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .ph_lo_en(ph_lo_en), .ph_hi_en(ph_hi_en),
    .pwm_in(pwm_in), .chop_mode(chop_mode), .flt_temp(flt_temp),
    .flt_volt(flt_volt), .flt_ilim(flt_ilim), .gate_hi(gate_hi), .gate_lo(gate_lo));

  function automatic string tag_of(item_t it, int p);
    if (it.tf) return "R8";
    if (it.lo_en[p] && it.hi_en[p]) return "R3";
    if (!it.lo_en[p] && !it.hi_en[p]) return "R2";
    if (it.ilim) return "R9";
    if (it.mode == 2'b00) return "R4";
    if (it.mode == 2'b10) return "R5";
    return "R6";
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b (hi,lo)", req, act, exp);
    end
  endtask

  task automatic apply(logic [NP-1:0] lo, logic [NP-1:0] hi, logic [1:0] m,
                       logic pw, logic ot, logic ov, logic cl);
    item_t it;
    logic  e;
    @(negedge clk);
    ph_lo_en = lo; ph_hi_en = hi; chop_mode = m; pwm_in = pw;
    flt_temp = ot; flt_volt = ov; flt_ilim = cl;
    it.lo_en = lo; it.hi_en = hi; it.mode = m; it.tf = ot | ov; it.ilim = cl;
    e = pw && !cl;
    for (int p = 0; p < NP; p++) begin
      it.e_hi[p] = 1'b0; it.e_lo[p] = 1'b0;
      if (!it.tf && (lo[p] ^ hi[p])) begin
        if (hi[p]) begin
          it.e_hi[p] = (m == 2'b10) ? 1'b1 : e;
          it.e_lo[p] = m[0] ? !e : 1'b0;
        end else begin
          it.e_lo[p] = (m == 2'b10) ? e : 1'b1;
        end
      end
    end
    q.push_back(it);
    #1;
    // R10: outputs must not move before the next rising edge
    for (int p = 0; p < NP; p++)
      check("R10", {gate_hi[p], gate_lo[p]}, {prev_hi[p], prev_lo[p]});
    prev_hi = it.e_hi; prev_lo = it.e_lo;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        for (int p = 0; p < NP; p++) begin
          check(tag_of(it, p), {gate_hi[p], gate_lo[p]}, {it.e_hi[p], it.e_lo[p]});
          check("R7", {1'b0, gate_hi[p] & gate_lo[p]}, 2'b00);
        end
      end
    end
  end

  // watchdog
  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: active requests during reset must not reach the gates
    ph_hi_en = '1; pwm_in = 1'b1; chop_mode = 2'b01;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {|gate_hi, |gate_lo}, 2'b00);
    @(negedge clk);
    ph_hi_en = '0; pwm_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    // exhaustive sweep: faults x mode x current limit x pwm x enables
    for (int f = 0; f < 4; f++)
      for (int m = 0; m < 4; m++)
        for (int c = 0; c < 2; c++)
          for (int w = 0; w < 2; w++)
            for (int v = 0; v < 64; v++)
              apply(v[2:0], v[5:3], m[1:0], w[0], f[0], f[1], c[0]);
    // PWM toggling in complementary mode on a single phase
    for (int k = 0; k < 8; k++)
      apply(3'b010, 3'b001, 2'b11, k[0], 1'b0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule